// File: doc/BRIEF.md
# Multi-Source Timed Reset Generator

This block merges several fault indications into timed reset outputs for a system with more than one supply rail. Two supply-good flags, an auxiliary-good flag, an active-low manual-reset request and a single-cycle watchdog-bite pulse are its inputs. Any of them pulls the main reset low. The main reset then stays low for a selectable hold period, counted from the last clock edge at which any fault was present. An active-high copy of the main reset is also driven. A secondary reset follows only the two supply flags and the manual request. A power-fail flag is passed combinationally to its own active-low output and never waits for a timer.

The comparators that produce the flags are outside the block; it sees only their digital results. Every level input from outside the clock domain crosses a two-flop synchroniser. The manual request also passes a glitch filter of `MR_FILT` clock cycles. The hold period is chosen by a 3-bit code. The code selects a tick count, and one tick lasts `TICK_DIV` clock cycles, nominally 50 us. Each timer has its own prescaler, which restarts together with the timer, so the hold length is exact to the cycle.

Top module: `rst_timeout_gen`

## Requirements
- R1: The main reset `rst_no` goes low at the third clock edge after a supply flag or the auxiliary flag drops. It also goes low one edge after the manual filter accepts a request.
- R2: Once every fault is gone, `rst_no` returns high exactly `TICK_DIV*P` clock cycles after the last edge at which a synchronised fault was seen. `P` is the tick count of the selected code.
- R3: A fault that returns before the hold completes restarts the count from zero. The release is then measured from the newest fault.
- R4: A one-cycle high on `wdt_bite_i` pulls `rst_no` low at the next edge. It holds it low for exactly `TICK_DIV*P` cycles. A bite that arrives during a hold restarts that hold.
- R5: `sec_rst_no` follows the two supply flags and the manual request with the same timing as R1 and R2. The auxiliary flag and the watchdog bite leave it high.
- R6: A manual-request low shorter than `MR_FILT` cycles changes no output. A low that lasts exactly `MR_FILT` cycles asserts both resets at edge `MR_FILT+3` after it starts. They release `TICK_DIV*P` cycles after that edge.
- R7: `tmo_sel_i` codes 0 to 7 select 33, 264, 525, 1050, 4200, 8400, 16800 and 33600 ticks respectively. These correspond to 1.65, 13.2, 26.25, 52.5, 210, 420, 840 and 1680 ms at 50 us per tick.
- R8: `pfail_no` equals `pwr_ok_i` in the same cycle, in both directions, and does not disturb the reset outputs.
- R9: `rst_o` is always the complement of `rst_no`.
- R10: While `rst_ni` is low, `rst_no` and `sec_rst_no` are low and `rst_o` is high. The synchronisers hold fault values, so the first release comes `TICK_DIV*P` cycles after the second edge following reset removal.
- R11: A change on a flag input has no effect on the outputs before the third clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tmo_sel_i | input | 3 | Hold period code |
| supa_ok_i | input | 1 | First supply good, asynchronous |
| supb_ok_i | input | 1 | Second supply good, asynchronous |
| ext_ok_i | input | 1 | Auxiliary monitor good, asynchronous |
| man_rst_ni | input | 1 | Manual reset request, active low, asynchronous |
| wdt_bite_i | input | 1 | Watchdog expiry, one-cycle pulse, synchronous |
| pwr_ok_i | input | 1 | Power-fail comparator result |
| rst_no | output | 1 | Main reset, active low |
| rst_o | output | 1 | Main reset, active high |
| sec_rst_no | output | 1 | Secondary reset, active low |
| pfail_no | output | 1 | Power-fail warning, active low |

## Verification
The two timers can finish and restart in the same cycle. This happens when a watchdog bite lands on exactly the edge where a supply fault's hold would end. The bench releases a supply fault and drives the bite so that it is seen on the secondary timer's release edge. It then expects `sec_rst_no` to rise at that edge while `rst_no` stays low for one further full period, counted from the bite. A second case has the auxiliary fault come back in the middle of a hold. In that case the old release point must pass with the reset still low.

// File: rtl/rst_timeout_gen.sv
module rst_timeout_gen #(
  parameter int TICK_DIV = 5000,
  parameter int MR_FILT  = 100,
  parameter int CNT_W    = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] tmo_sel_i,
  input  logic       supa_ok_i,
  input  logic       supb_ok_i,
  input  logic       ext_ok_i,
  input  logic       man_rst_ni,
  input  logic       wdt_bite_i,
  input  logic       pwr_ok_i,
  output logic       rst_no,
  output logic       rst_o,
  output logic       sec_rst_no,
  output logic       pfail_no
);

  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int MF_W  = (MR_FILT > 1) ? $clog2(MR_FILT) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);
  localparam logic [MF_W-1:0]  MF_LAST  = MF_W'(MR_FILT - 1);

  function automatic logic [CNT_W-1:0] ticks_for(input logic [2:0] code);
    case (code)
      3'd0:    return CNT_W'(33);
      3'd1:    return CNT_W'(264);
      3'd2:    return CNT_W'(525);
      3'd3:    return CNT_W'(1050);
      3'd4:    return CNT_W'(4200);
      3'd5:    return CNT_W'(8400);
      3'd6:    return CNT_W'(16800);
      default: return CNT_W'(33600);
    endcase
  endfunction

  // two-flop synchronisers: {manual, aux, supply b, supply a}
  logic [3:0] sync1, sync2;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sync1 <= 4'b1000;
      sync2 <= 4'b1000;
    end else begin
      sync1 <= {man_rst_ni, ext_ok_i, supb_ok_i, supa_ok_i};
      sync2 <= sync1;
    end

  logic supa_s, supb_s, ext_s, mr_s;
  assign {mr_s, ext_s, supb_s, supa_s} = sync2;

  // manual request glitch filter
  logic [MF_W-1:0] mr_cnt;
  logic            mr_act;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      mr_cnt <= '0;
      mr_act <= 1'b0;
    end else if (mr_s) begin
      mr_cnt <= '0;
      mr_act <= 1'b0;
    end else if (mr_cnt != MF_LAST) begin
      mr_cnt <= mr_cnt + 1'b1;
    end else begin
      mr_act <= 1'b1;
    end

  logic [1:0] fault, kick, hold;
  assign fault[1] = !supa_s || !supb_s || mr_act;
  assign fault[0] = fault[1] || !ext_s;
  assign kick     = {1'b0, wdt_bite_i};

  logic [CNT_W-1:0] last_tick;
  assign last_tick = ticks_for(tmo_sel_i) - 1'b1;

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic [PRE_W-1:0] pre;
    logic [CNT_W-1:0] cnt;
    logic             hld;
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni) begin
        hld <= 1'b1;
        pre <= '0;
        cnt <= '0;
      end else if (fault[ch] || kick[ch]) begin
        hld <= 1'b1;
        pre <= '0;
        cnt <= '0;
      end else if (hld) begin
        if (pre == PRE_LAST) begin
          pre <= '0;
          if (cnt == last_tick) begin
            hld <= 1'b0;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else begin
          pre <= pre + 1'b1;
        end
      end
    assign hold[ch] = hld;
  end

  assign rst_no     = ~hold[0];
  assign rst_o      = hold[0];
  assign sec_rst_no = ~hold[1];
  assign pfail_no   = pwr_ok_i;

  AST_FAULT_ASSERTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault[0] |=> !rst_no); // R1
  AST_RELEASE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_no) |-> $past(!fault[0] && !wdt_bite_i)); // R2
  AST_BITE_ASSERTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_bite_i |=> !rst_no); // R4
  AST_SEC_ASSERTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault[1] |=> !sec_rst_no); // R5
  AST_MR_FILTERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mr_act) |-> $past(!mr_s)); // R6
  AST_POLARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o != rst_no); // R9

endmodule

// File: tb/rst_timeout_gen_test.sv
module rst_timeout_gen_test;
  localparam int DIV = 2;
  localparam int MRF = 4;
  localparam int DP  = DIV * 33;

  logic clk = 0, rst_ni = 0;
  logic [2:0] tmo_sel = 0;
  logic supa = 1, supb = 1, ext = 1, mr_n = 1, wdt = 0, pwr = 1;
  logic rst_n, rst, sec_n, pf_n;

  rst_timeout_gen #(.TICK_DIV(DIV), .MR_FILT(MRF), .CNT_W(16)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .tmo_sel_i(tmo_sel),
    .supa_ok_i(supa), .supb_ok_i(supb), .ext_ok_i(ext), .man_rst_ni(mr_n),
    .wdt_bite_i(wdt), .pwr_ok_i(pwr),
    .rst_no(rst_n), .rst_o(rst), .sec_rst_no(sec_n), .pfail_no(pf_n));

  always #5 clk = ~clk;

  typedef struct { int cyc; int sig; logic val; string req; } exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(int dc, int sig, logic val, string req);
    exp_t e;
    e.cyc = cyc + dc; e.sig = sig; e.val = val; e.req = req;
    q.push_back(e);
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expectations whose cycle has come
  always begin
    @(negedge clk);
    #1;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].cyc <= cyc) begin
        logic act;
        case (q[i].sig)
          0: act = rst_n;
          1: act = rst;
          2: act = sec_n;
          default: act = pf_n;
        endcase
        checks++;
        if (act !== q[i].val) begin
          errors++;
          $display("FAIL %s sig%0d at cycle %0d: actual=%b expected=%b",
                   q[i].req, q[i].sig, cyc, act, q[i].val);
        end
        q.delete(i);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    expect_at(0, 0, 0, "R10"); expect_at(0, 1, 1, "R10"); expect_at(0, 2, 0, "R10");
    rst_ni = 1;
    expect_at(1 + DP, 0, 0, "R10"); expect_at(2 + DP, 0, 1, "R10");
    expect_at(2 + DP, 2, 1, "R10"); expect_at(2 + DP, 1, 0, "R9");
    wait_cyc(DP + 8);

    // supply fault
    supa = 0;
    expect_at(2, 0, 1, "R11"); expect_at(3, 0, 0, "R1"); expect_at(3, 2, 0, "R5");
    wait_cyc(6);
    supa = 1;
    expect_at(1 + DP, 0, 0, "R2"); expect_at(2 + DP, 0, 1, "R2");
    expect_at(1 + DP, 2, 0, "R5"); expect_at(2 + DP, 2, 1, "R5");
    wait_cyc(DP + 8);

    // auxiliary fault: secondary untouched
    ext = 0;
    expect_at(3, 0, 0, "R1"); expect_at(3, 1, 1, "R9");
    expect_at(3, 2, 1, "R5"); expect_at(8, 2, 1, "R5");
    wait_cyc(6);
    ext = 1;
    expect_at(2 + DP, 0, 1, "R2");
    wait_cyc(DP + 8);

    // restart during hold
    ext = 0; wait_cyc(4);
    ext = 1; wait_cyc(20);
    ext = 0; wait_cyc(2);
    ext = 1;
    expect_at(2 + DP - 22, 0, 0, "R3");
    expect_at(1 + DP, 0, 0, "R3"); expect_at(2 + DP, 0, 1, "R3");
    wait_cyc(DP + 8);

    // watchdog bite
    wdt = 1;
    expect_at(1, 0, 0, "R4"); expect_at(1, 2, 1, "R5");
    expect_at(DP, 0, 0, "R4"); expect_at(DP + 1, 0, 1, "R4");
    wait_cyc(1); wdt = 0;
    wait_cyc(DP + 8);

    // manual glitch, then minimum accepted pulse
    mr_n = 0;
    expect_at(8, 0, 1, "R6"); expect_at(12, 2, 1, "R6"); expect_at(20, 0, 1, "R6");
    wait_cyc(MRF - 1); mr_n = 1;
    wait_cyc(25);
    mr_n = 0;
    expect_at(MRF + 2, 0, 1, "R6"); expect_at(MRF + 3, 0, 0, "R6");
    expect_at(MRF + 3, 2, 0, "R6");
    expect_at(MRF + 2 + DP, 0, 0, "R6"); expect_at(MRF + 3 + DP, 0, 1, "R6");
    wait_cyc(MRF); mr_n = 1;
    wait_cyc(DP + 12);

    // power-fail pass-through
    pwr = 0;
    expect_at(0, 3, 0, "R8"); expect_at(2, 0, 1, "R8");
    wait_cyc(3);
    pwr = 1;
    expect_at(0, 3, 1, "R8"); expect_at(2, 0, 1, "R8");
    wait_cyc(4);

    // bite on the secondary release edge
    supa = 0; wait_cyc(5);
    supa = 1;
    expect_at(2 + DP, 2, 1, "R5"); expect_at(2 + DP, 0, 0, "R4");
    wait_cyc(1 + DP);
    wdt = 1;
    expect_at(DP, 0, 0, "R4"); expect_at(DP + 1, 0, 1, "R4");
    wait_cyc(1); wdt = 0;
    wait_cyc(DP + 8);

    // period codes
    tmo_sel = 3'd1; wait_cyc(4);
    supb = 0; wait_cyc(5);
    supb = 1;
    expect_at(1 + DIV * 264, 0, 0, "R7"); expect_at(2 + DIV * 264, 0, 1, "R7");
    wait_cyc(DIV * 264 + 8);

    tmo_sel = 3'd3; wait_cyc(4);
    wdt = 1;
    expect_at(DIV * 1050, 0, 0, "R7"); expect_at(DIV * 1050 + 1, 0, 1, "R7");
    wait_cyc(1); wdt = 0;
    wait_cyc(DIV * 1050 + 8);

    tmo_sel = 3'd7; wait_cyc(4);
    wdt = 1;
    expect_at(DIV * 33600, 0, 0, "R7"); expect_at(DIV * 33600 + 1, 0, 1, "R7");
    wait_cyc(1); wdt = 0;
    wait_cyc(DIV * 33600 + 8);

    wait (q.size() == 0);
    wait_cyc(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule